// File: doc/BRIEF.md
# Link Address Overlay and Lookup Translator

This block sits on the address path of a memory-mapped link between two chips. It has two independent halves. The transmit half takes a local 32-bit address and a 4-bit privilege ID. It clears the address bits the link does not carry, writes the privilege ID into a field higher up, and can optionally add a security bit. The result is the address that goes out on the link.

The receive half takes an incoming link address. It recovers the privilege ID and an optional security bit from configurable positions. It also cuts a 6-bit line index out of a configurable field. That index selects one of 64 translation lines. Each line holds a remote base address, a size code and a valid bit. The bits below the index field form an offset, which is added to the line's base. A line that is not valid, that has size code 0 (nonexistent memory), or whose offset falls outside the segment rejects the access.

All selectors are coded as a 4-bit setting `s`, and a field position is `s + 16`. A privilege setting of 12 therefore means bits 31:28, and segment settings of 9 and 6 mean bits 30:25 and bits 27:22. The table is loaded through a simple write port. Both halves answer one cycle after their request.

Top module: `link_addr_xlate`

## Requirements
- R1: On transmit, a mask setting `m` keeps address bits `m+16` down to 0 (m=11 keeps bits 27:0) and clears all bits above them before any overlay is applied.
- R2: On transmit, a privilege setting `p` overwrites bits `p+19..p+16` of the masked address with the 4-bit privilege ID (p=12 gives bits 31:28). Any part of that field above bit 31 is dropped.
- R3: With the transmit security overlay enabled, bit `p+15` of the output carries the security input. With it disabled, that bit follows the masked address.
- R4: On receive, the privilege ID output is bits `p+19..p+16` of the incoming address. The security output is bit `p+15` when the receive security enable is set, and 0 when it is clear.
- R5: On receive, a segment setting `g` selects bits `g+21..g+16` as the 6-bit line index (g=9 gives bits 30:25, g=6 gives bits 27:22).
- R6: For an accepted access, the remote address is the line's base plus the offset. The offset is the incoming bits below the index field, and the sum wraps at 32 bits.
- R7: Size code `z` allows offsets below 2^z (z=25 is 32 MB, z=22 is 4 MB). A larger offset raises the error flag instead of the valid flag and returns remote address 0.
- R8: A request that hits a line with its valid bit clear, or with size code 0, raises the error flag and returns remote address 0.
- R9: Reset clears every line's valid bit and drives both valid flags and the error flag low.
- R10: A write to line `i` takes effect for receive requests from the next cycle. A request in the same cycle as the write sees the old contents. Other lines are left unchanged.
- R11: The transmit valid flag rises exactly one cycle after a transmit request. Each receive request produces exactly one of the receive valid flag or the error flag one cycle later.
- R12: In a cycle after no receive request, the receive valid flag and the error flag are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| txReq | input | 1 | Transmit translation request |
| txAddrIn | input | 32 | Local address to send |
| txPrivIn | input | 4 | Requester privilege ID |
| txSecIn | input | 1 | Security bit to insert |
| txMaskSel | input | 4 | Mask setting (keeps bits up to setting+16) |
| txPrivSel | input | 4 | Privilege field setting (field low bit at setting+16) |
| txSecEn | input | 1 | Enables the transmit security overlay |
| txValid | output | 1 | Transmit result valid |
| txAddrOut | output | 32 | Link address |
| rxReq | input | 1 | Receive translation request |
| rxAddrIn | input | 32 | Incoming link address |
| rxPrivSel | input | 4 | Privilege field setting on receive |
| rxSegSel | input | 4 | Index field setting (field low bit at setting+16) |
| rxSecEn | input | 1 | Enables extraction of the security bit |
| rxValid | output | 1 | Access accepted |
| rxErr | output | 1 | Access rejected |
| rxRemoteAddr | output | 32 | Translated remote address, 0 on rejection |
| rxPrivOut | output | 4 | Recovered privilege ID |
| rxSecOut | output | 1 | Recovered security bit |
| wrEn | input | 1 | Table line write strobe |
| wrIdx | input | 6 | Line to write |
| wrBase | input | 32 | Base address for the line |
| wrSize | input | 5 | Size code (log2 of bytes, 0 = no memory) |
| wrValid | input | 1 | Valid bit for the line |

## Verification
The transmit half is swept over every mask setting, every privilege setting and both security modes. A model that builds the output one bit at a time separates masking from overlay, catches fields placed one bit off, and catches security bits lost at the field edge. The receive half runs through all 64 lines under both index settings used on the link. Per line it uses a zero offset, the last offset inside the segment, and the first offset past it. A table that mixes 32 MB lines, 4 MB lines, lines with no memory and lines never validated makes every accept and reject path visible in the remote address. Further cases cover a write that collides with a read of the same line and idle cycles between requests.

// File: rtl/link_xlate_pkg.sv
package link_xlate_pkg;

  // Strobes handed from the control path to the datapath each cycle.
  typedef struct packed {
    logic txCapture;
    logic rxCapture;
    logic tblWrite;
  } xlateStb_t;

endpackage

// File: rtl/link_xlate_ctrl.sv
module link_xlate_ctrl
  import link_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      txReq,
  input  logic      rxReq,
  input  logic      wrEn,
  output xlateStb_t stb,
  output logic      txValid,
  output logic      rxDone
);

  always_comb begin
    stb.txCapture = txReq;
    stb.rxCapture = rxReq;
    stb.tblWrite  = wrEn;
  end

  // One-cycle response timing for both halves.
  always_ff @(posedge clk) begin
    if (rst) begin
      txValid <= 1'b0;
      rxDone  <= 1'b0;
    end else begin
      txValid <= txReq;
      rxDone  <= rxReq;
    end
  end

endmodule

// File: rtl/link_xlate_dp.sv
module link_xlate_dp
  import link_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PRIV_W   = 4,
  parameter int IDX_W    = 6,
  parameter int SEL_W    = 4,
  parameter int SIZE_W   = 5,
  parameter int SEL_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  xlateStb_t         stb,
  input  logic [ADDR_W-1:0] txAddrIn,
  input  logic [PRIV_W-1:0] txPrivIn,
  input  logic              txSecIn,
  input  logic [SEL_W-1:0]  txMaskSel,
  input  logic [SEL_W-1:0]  txPrivSel,
  input  logic              txSecEn,
  input  logic [ADDR_W-1:0] rxAddrIn,
  input  logic [SEL_W-1:0]  rxPrivSel,
  input  logic [SEL_W-1:0]  rxSegSel,
  input  logic              rxSecEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic              wrValid,
  output logic [ADDR_W-1:0] txAddrQ,
  output logic [ADDR_W-1:0] rxAddrQ,
  output logic [PRIV_W-1:0] rxPrivQ,
  output logic              rxSecQ,
  output logic              rxHitQ
);

  localparam int LINES = 1 << IDX_W;
  localparam int LSB_W = $clog2(ADDR_W) + 2;
  localparam logic [ADDR_W-1:0] ALL1 = '1;

  // ---------------- translation table ----------------
  logic [ADDR_W-1:0] baseTbl  [LINES];
  logic [SIZE_W-1:0] sizeTbl  [LINES];
  logic              validTbl [LINES];

  for (genvar g = 0; g < LINES; g++) begin : gLine
    always_ff @(posedge clk) begin
      if (rst) begin
        validTbl[g] <= 1'b0;
        baseTbl[g]  <= '0;
        sizeTbl[g]  <= '0;
      end else if (stb.tblWrite && wrIdx == IDX_W'(g)) begin
        validTbl[g] <= wrValid;
        baseTbl[g]  <= wrBase;
        sizeTbl[g]  <= wrSize;
      end
    end
  end

  // ---------------- transmit overlay ----------------
  logic [LSB_W-1:0]  txKeepBits;
  logic [LSB_W-1:0]  txPrivLsb;
  logic [ADDR_W-1:0] txKeepMask;
  logic [ADDR_W-1:0] txFieldMask;
  logic [ADDR_W-1:0] txSecMask;
  logic [ADDR_W-1:0] txNext;

  always_comb begin
    txKeepBits  = LSB_W'(txMaskSel) + LSB_W'(SEL_BASE + 1);
    txPrivLsb   = LSB_W'(txPrivSel) + LSB_W'(SEL_BASE);
    txKeepMask  = ~(ALL1 << txKeepBits);
    txFieldMask = ADDR_W'({PRIV_W{1'b1}}) << txPrivLsb;
    txSecMask   = (txSecEn && txPrivLsb != '0) ?
                  (ADDR_W'(1) << (txPrivLsb - LSB_W'(1))) : '0;
    txNext      = txAddrIn & txKeepMask & ~txFieldMask & ~txSecMask;
    txNext      = txNext | (ADDR_W'(txPrivIn) << txPrivLsb);
    if (txSecIn) txNext = txNext | txSecMask;
  end

  always_ff @(posedge clk) begin
    if (rst)                txAddrQ <= '0;
    else if (stb.txCapture) txAddrQ <= txNext;
  end

  // ---------------- receive extraction and lookup ----------------
  logic [LSB_W-1:0]  rxPrivLsb;
  logic [LSB_W-1:0]  rxSegLsb;
  logic [PRIV_W-1:0] rxPrivId;
  logic              rxSecBit;
  logic [IDX_W-1:0]  rxIdx;
  logic [ADDR_W-1:0] rxOffset;
  logic [ADDR_W-1:0] lineBase;
  logic [SIZE_W-1:0] lineSize;
  logic              lineValid;
  logic              inRange;
  logic              rxHit;
  logic [ADDR_W-1:0] rxRemote;

  always_comb begin
    rxPrivLsb = LSB_W'(rxPrivSel) + LSB_W'(SEL_BASE);
    rxSegLsb  = LSB_W'(rxSegSel) + LSB_W'(SEL_BASE);
    rxPrivId  = PRIV_W'(rxAddrIn >> rxPrivLsb);
    rxSecBit  = rxSecEn && rxPrivLsb != '0 &&
                1'(rxAddrIn >> (rxPrivLsb - LSB_W'(1)));
    rxIdx     = IDX_W'(rxAddrIn >> rxSegLsb);
    rxOffset  = rxAddrIn & ~(ALL1 << rxSegLsb);
    lineBase  = baseTbl[rxIdx];
    lineSize  = sizeTbl[rxIdx];
    lineValid = validTbl[rxIdx];
    // Offset fits when nothing remains above the segment size.
    inRange   = (rxOffset >> lineSize) == '0;
    rxHit     = lineValid && (lineSize != '0) && inRange;
    rxRemote  = rxHit ? (lineBase + rxOffset) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxAddrQ <= '0;
      rxPrivQ <= '0;
      rxSecQ  <= 1'b0;
      rxHitQ  <= 1'b0;
    end else if (stb.rxCapture) begin
      rxAddrQ <= rxRemote;
      rxPrivQ <= rxPrivId;
      rxSecQ  <= rxSecBit;
      rxHitQ  <= rxHit;
    end
  end

endmodule

// File: rtl/link_addr_xlate.sv
module link_addr_xlate
  import link_xlate_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int PRIV_W   = 4,
  parameter int IDX_W    = 6,
  parameter int SEL_W    = 4,
  parameter int SIZE_W   = 5,
  parameter int SEL_BASE = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              txReq,
  input  logic [ADDR_W-1:0] txAddrIn,
  input  logic [PRIV_W-1:0] txPrivIn,
  input  logic              txSecIn,
  input  logic [SEL_W-1:0]  txMaskSel,
  input  logic [SEL_W-1:0]  txPrivSel,
  input  logic              txSecEn,
  output logic              txValid,
  output logic [ADDR_W-1:0] txAddrOut,
  input  logic              rxReq,
  input  logic [ADDR_W-1:0] rxAddrIn,
  input  logic [SEL_W-1:0]  rxPrivSel,
  input  logic [SEL_W-1:0]  rxSegSel,
  input  logic              rxSecEn,
  output logic              rxValid,
  output logic              rxErr,
  output logic [ADDR_W-1:0] rxRemoteAddr,
  output logic [PRIV_W-1:0] rxPrivOut,
  output logic              rxSecOut,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrBase,
  input  logic [SIZE_W-1:0] wrSize,
  input  logic              wrValid
);

  xlateStb_t stb;
  logic      rxDone;
  logic      rxHitQ;

  link_xlate_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .txReq   (txReq),
    .rxReq   (rxReq),
    .wrEn    (wrEn),
    .stb     (stb),
    .txValid (txValid),
    .rxDone  (rxDone)
  );

  link_xlate_dp #(
    .ADDR_W   (ADDR_W),
    .PRIV_W   (PRIV_W),
    .IDX_W    (IDX_W),
    .SEL_W    (SEL_W),
    .SIZE_W   (SIZE_W),
    .SEL_BASE (SEL_BASE)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .stb       (stb),
    .txAddrIn  (txAddrIn),
    .txPrivIn  (txPrivIn),
    .txSecIn   (txSecIn),
    .txMaskSel (txMaskSel),
    .txPrivSel (txPrivSel),
    .txSecEn   (txSecEn),
    .rxAddrIn  (rxAddrIn),
    .rxPrivSel (rxPrivSel),
    .rxSegSel  (rxSegSel),
    .rxSecEn   (rxSecEn),
    .wrIdx     (wrIdx),
    .wrBase    (wrBase),
    .wrSize    (wrSize),
    .wrValid   (wrValid),
    .txAddrQ   (txAddrOut),
    .rxAddrQ   (rxRemoteAddr),
    .rxPrivQ   (rxPrivOut),
    .rxSecQ    (rxSecOut),
    .rxHitQ    (rxHitQ)
  );

  assign rxValid = rxDone & rxHitQ;
  assign rxErr   = rxDone & ~rxHitQ;

endmodule

// File: rtl/link_addr_xlate_chk.sv
module link_addr_xlate_chk #(
  parameter int ADDR_W   = 32,
  parameter int PRIV_W   = 4,
  parameter int SEL_W    = 4,
  parameter int SEL_BASE = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              txReq,
  input logic [ADDR_W-1:0] txAddrIn,
  input logic [PRIV_W-1:0] txPrivIn,
  input logic [SEL_W-1:0]  txPrivSel,
  input logic              txSecEn,
  input logic              txValid,
  input logic [ADDR_W-1:0] txAddrOut,
  input logic              rxReq,
  input logic [ADDR_W-1:0] rxAddrIn,
  input logic [SEL_W-1:0]  rxPrivSel,
  input logic              rxValid,
  input logic              rxErr,
  input logic [ADDR_W-1:0] rxRemoteAddr,
  input logic [PRIV_W-1:0] rxPrivOut
);

  localparam logic [SEL_W-1:0] TOP_SEL = SEL_W'(ADDR_W - PRIV_W - SEL_BASE);

  // R1: bits below the lowest possible overlay position pass untouched
  a_r1_low_bits_kept: assert property (@(posedge clk) disable iff (rst)
    txValid && !$past(txSecEn) |->
      txAddrOut[SEL_BASE-1:0] == $past(txAddrIn[SEL_BASE-1:0]));

  // R2: privilege ID lands in the top field for the top setting
  a_r2_priv_top: assert property (@(posedge clk) disable iff (rst)
    txValid && $past(txPrivSel) == TOP_SEL |->
      txAddrOut[ADDR_W-1 -: PRIV_W] == $past(txPrivIn));

  // R4: receive privilege recovered from the top field
  a_r4_priv_extract: assert property (@(posedge clk) disable iff (rst)
    (rxValid || rxErr) && $past(rxPrivSel) == TOP_SEL |->
      rxPrivOut == $past(rxAddrIn[ADDR_W-1 -: PRIV_W]));

  // R7 and R8: a rejected access returns address zero
  a_r8_reject_zero: assert property (@(posedge clk) disable iff (rst)
    rxErr |-> rxRemoteAddr == '0);

  // R9: flags low right after reset
  a_r9_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !txValid && !rxValid && !rxErr);

  // R11: transmit answers exactly one cycle later
  a_r11_tx_latency: assert property (@(posedge clk) disable iff (rst)
    txReq |=> txValid);

  a_r11_tx_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !txReq |=> !txValid);

  // R11: each receive request gives exactly one outcome
  a_r11_rx_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rxReq |=> (rxValid ^ rxErr));

  // R12: no outcome without a request
  a_r12_rx_idle: assert property (@(posedge clk) disable iff (rst)
    !rxReq |=> !rxValid && !rxErr);

endmodule

bind link_addr_xlate link_addr_xlate_chk #(
  .ADDR_W   (ADDR_W),
  .PRIV_W   (PRIV_W),
  .SEL_W    (SEL_W),
  .SEL_BASE (SEL_BASE)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .txReq        (txReq),
  .txAddrIn     (txAddrIn),
  .txPrivIn     (txPrivIn),
  .txPrivSel    (txPrivSel),
  .txSecEn      (txSecEn),
  .txValid      (txValid),
  .txAddrOut    (txAddrOut),
  .rxReq        (rxReq),
  .rxAddrIn     (rxAddrIn),
  .rxPrivSel    (rxPrivSel),
  .rxValid      (rxValid),
  .rxErr        (rxErr),
  .rxRemoteAddr (rxRemoteAddr),
  .rxPrivOut    (rxPrivOut)
);

// File: tb/link_addr_xlate_bench.sv
`timescale 1ns/1ps
module link_addr_xlate_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        txReq = 1'b0;
  logic [31:0] txAddrIn = '0;
  logic [3:0]  txPrivIn = '0;
  logic        txSecIn = 1'b0;
  logic [3:0]  txMaskSel = '0;
  logic [3:0]  txPrivSel = '0;
  logic        txSecEn = 1'b0;
  logic        txValid;
  logic [31:0] txAddrOut;
  logic        rxReq = 1'b0;
  logic [31:0] rxAddrIn = '0;
  logic [3:0]  rxPrivSel = 4'd12;
  logic [3:0]  rxSegSel = 4'd9;
  logic        rxSecEn = 1'b0;
  logic        rxValid;
  logic        rxErr;
  logic [31:0] rxRemoteAddr;
  logic [3:0]  rxPrivOut;
  logic        rxSecOut;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [31:0] wrBase = '0;
  logic [4:0]  wrSize = '0;
  logic        wrValid = 1'b0;

  always #2 clk = ~clk;

  link_addr_xlate u_link_addr_xlate (
    .clk(clk), .rst(rst),
    .txReq(txReq), .txAddrIn(txAddrIn), .txPrivIn(txPrivIn), .txSecIn(txSecIn),
    .txMaskSel(txMaskSel), .txPrivSel(txPrivSel), .txSecEn(txSecEn),
    .txValid(txValid), .txAddrOut(txAddrOut),
    .rxReq(rxReq), .rxAddrIn(rxAddrIn), .rxPrivSel(rxPrivSel), .rxSegSel(rxSegSel),
    .rxSecEn(rxSecEn), .rxValid(rxValid), .rxErr(rxErr),
    .rxRemoteAddr(rxRemoteAddr), .rxPrivOut(rxPrivOut), .rxSecOut(rxSecOut),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrBase(wrBase), .wrSize(wrSize), .wrValid(wrValid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Bench's own record of what it wrote into the table.
  logic [31:0] mBase  [64];
  logic [4:0]  mSize  [64];
  logic        mValid [64];

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] txModel(input logic [31:0] a, input logic [3:0] pr,
      input logic sc, input int ms, input int ps, input logic se);
    logic [31:0] r = '0;
    int plsb = ps + 16;
    int keep = ms + 17;
    for (int b = 0; b < 32; b++) begin
      if (b >= plsb && b < plsb + 4) r[b] = pr[b - plsb];
      else if (se && b == plsb - 1) r[b] = sc;
      else if (b < keep) r[b] = a[b];
      else r[b] = 1'b0;
    end
    return r;
  endfunction

  task automatic writeLine(input int i, input logic [31:0] b, input logic [4:0] z, input logic v);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'(i); wrBase = b; wrSize = z; wrValid = v;
    @(negedge clk);
    wrEn = 1'b0;
    mBase[i] = b; mSize[i] = z; mValid[i] = v;
  endtask

  task automatic rxOnce(input logic [31:0] a);
    @(negedge clk);
    rxReq = 1'b1; rxAddrIn = a;
    @(negedge clk);
    rxReq = 1'b0;
  endtask

  // Expected outcome of a receive request against the bench's table record.
  task automatic rxExpect(input string tag, input logic [31:0] a, input int segLsb);
    int idx = int'((a >> segLsb) & 32'h3F);
    logic [31:0] off = a & ((32'h1 << segLsb) - 32'h1);
    longint lim = longint'(1) << mSize[idx];
    bit hit = mValid[idx] && mSize[idx] != 0 && longint'(off) < lim;
    check(tag, {30'b0, rxValid, rxErr}, hit ? 32'h2 : 32'h1);
    check(tag, rxRemoteAddr, hit ? mBase[idx] + off : 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mBase[i] = '0; mSize[i] = '0; mValid[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: quiet outputs after reset
    check("R9 flags", {29'b0, txValid, rxValid, rxErr}, 32'h0);
    // R9: every line invalid after reset, so any request is rejected
    rxSegSel = 4'd9;
    rxOnce(32'h1234_5678);
    check("R9 R8 empty table", {30'b0, rxValid, rxErr}, 32'h1);

    // R1 R2 R3: full sweep of transmit settings
    for (int ms = 0; ms < 16; ms++) begin
      for (int ps = 0; ps < 16; ps++) begin
        for (int se = 0; se < 2; se++) begin
          logic [31:0] a = 32'hA5C3_0000 ^ (32'h9E37_79B9 * (ms * 16 + ps)) ^ 32'(se);
          logic [3:0] pr = 4'(ps * 7 + ms);
          logic sc = 1'((ms + ps + se) & 1);
          @(negedge clk);
          txReq = 1'b1; txAddrIn = a; txPrivIn = pr; txSecIn = sc;
          txMaskSel = 4'(ms); txPrivSel = 4'(ps); txSecEn = 1'(se);
          @(negedge clk);
          txReq = 1'b0;
          check("R11 tx valid", {31'b0, txValid}, 32'h1);
          check(se ? "R3 R2 R1 tx" : "R1 R2 tx", txAddrOut,
                txModel(a, pr, sc, ms, ps, 1'(se)));
        end
      end
    end
    @(negedge clk);
    check("R11 tx drop", {31'b0, txValid}, 32'h0);

    // Table: 32 MB and 4 MB lines, no-memory lines, never-validated lines.
    for (int i = 0; i < 64; i++) begin
      logic [4:0] z = (i % 8 == 7) ? 5'd0 : ((i % 4 == 3) ? 5'd22 : 5'd25);
      writeLine(i, 32'h4000_0000 + 32'(i) * 32'h0100_0000 + 32'(i * 16), z, (i % 8) != 6);
    end

    // R5 R6 R7 R8: every line under both index settings
    for (int gs = 0; gs < 2; gs++) begin
      int segLsb = gs ? 22 : 25;
      rxSegSel = gs ? 4'd6 : 4'd9;
      for (int i = 0; i < 64; i++) begin
        logic [31:0] hiBits = gs ? (32'((i * 5) & 15) << 28) : (32'((i + 1) & 1) << 31);
        logic [31:0] fieldMax = (32'h1 << segLsb) - 32'h1;
        logic [31:0] lim = 32'h1 << mSize[i];
        logic [31:0] offs [3];
        offs[0] = 32'h0;
        offs[1] = (mSize[i] != 0 && lim - 1 <= fieldMax) ? lim - 1 : fieldMax;
        offs[2] = (mSize[i] != 0 && lim <= fieldMax) ? lim : 32'(i * 1031) & fieldMax;
        for (int k = 0; k < 3; k++) begin
          logic [31:0] a = hiBits | (32'(i) << segLsb) | offs[k];
          string tag;
          if (!mValid[i] || mSize[i] == 0) tag = "R8 R5 reject";
          else if (longint'(offs[k]) >= (longint'(1) << mSize[i])) tag = "R7 R5 range";
          else tag = "R6 R5 remote";
          rxOnce(a);
          rxExpect(tag, a, segLsb);
          check("R4 priv", {28'b0, rxPrivOut}, a >> 28);
        end
      end
    end

    // R12: idle cycle produces no outcome
    @(negedge clk);
    check("R12 idle", {30'b0, rxValid, rxErr}, 32'h0);

    // R4: privilege and security extraction across settings
    for (int ps = 0; ps < 13; ps++) begin
      for (int se = 0; se < 2; se++) begin
        logic [31:0] a = 32'hD3B7_19E5 ^ (32'(ps) << 9);
        rxPrivSel = 4'(ps); rxSecEn = 1'(se);
        rxOnce(a);
        check("R4 priv sweep", {28'b0, rxPrivOut}, (a >> (ps + 16)) & 32'hF);
        check("R4 sec", {31'b0, rxSecOut}, se ? ((a >> (ps + 15)) & 32'h1) : 32'h0);
      end
    end
    rxPrivSel = 4'd12; rxSecEn = 1'b0;

    // R10: write and read of the same line in one cycle sees old contents
    rxSegSel = 4'd9;
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'd5; wrBase = 32'h7700_0000; wrSize = 5'd22; wrValid = 1'b1;
    rxReq = 1'b1; rxAddrIn = (32'd5 << 25) | 32'h0000_0100;
    @(negedge clk);
    wrEn = 1'b0; rxReq = 1'b0;
    check("R10 old contents", rxRemoteAddr, mBase[5] + 32'h100);
    mBase[5] = 32'h7700_0000; mSize[5] = 5'd22; mValid[5] = 1'b1;
    rxOnce((32'd5 << 25) | 32'h0000_0100);
    check("R10 new contents", rxRemoteAddr, 32'h7700_0100);
    rxOnce((32'd5 << 25) | 32'h0040_0000);
    check("R10 R7 new size", {30'b0, rxValid, rxErr}, 32'h1);
    rxOnce((32'd4 << 25) | 32'h0040_0000);
    rxExpect("R10 neighbour", (32'd4 << 25) | 32'h0040_0000, 25);
    // R8: clearing the valid bit blocks the line
    writeLine(4, mBase[4], mSize[4], 1'b0);
    rxOnce(32'd4 << 25);
    check("R8 invalidated", {30'b0, rxValid, rxErr}, 32'h1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule